// File: doc/BRIEF.md
# Prioritized Interrupt Dispatcher with Transfer Offload

The block collects sixteen interrupt request lines and decides, at each instruction boundary of the processor, which line is acknowledged next. A per-line select mask sends each line to one of two places. A line with its select bit clear is served by a normal software routine. A line with its select bit set is served by a hardware transfer-service channel, which has its own vector table. The block reports the chosen vector address and a flag that tells the processor which kind of service is starting.

Every line has a countdown counter. The external transfer engine pulses a per-line decrement strobe after each transfer it completes. When the counter reaches zero while the line is routed to the transfer path, the block does three things: it withdraws the line from transfer service, it raises an end-of-service request, and it later dispatches that request through the line's normal vector at the line's own priority.

Acknowledgement waits for the processor's instruction-end strobe. A request that first appears while the processor signals the late phase of an instruction is held back by one extra instruction boundary.

Top module: `irq_xfer_dispatch`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `disp_valid` is 0. The select mask, pending, end-of-service and count state all reset to zero.
- R2: `disp_valid` pulses for one cycle, in the cycle after a cycle in which `insn_end` and `glb_en` are both 1 and at least one line is eligible. No dispatch happens at any other time.
- R3: Among eligible lines, the line with the highest index is dispatched first.
- R4: A line with its select bit clear is dispatched at vector 0x2020 + 2*index, with `disp_xfer` = 0. For example, line 11 uses 0x2036.
- R5: A line with its select bit set is dispatched at vector 0x2040 + 2*index, with `disp_xfer` = 1. For example, line 11 uses 0x2056.
- R6: A decrement strobe moves a nonzero count down by one and has no effect on a zero count. When the count goes from 1 to 0, the line's select bit clears. If the select bit was set at that moment, the line's end-of-service request is also set.
- R7: An end-of-service request is dispatched at the line's normal vector with `disp_xfer` = 0, at the same priority as the line's ordinary requests. It takes precedence over an ordinary request pending on the same line, and dispatching it clears it.
- R8: A request that arrives while `late_phase` = 1 (and `insn_end` = 0) is not eligible at the next `insn_end`. It becomes eligible at the boundary after that.
- R9: Dispatching an ordinary request clears that line's pending bit. A line whose `line_mask` bit is 0 is never dispatched but stays pending. Lines are also held while `glb_en` = 0.
- R10: When `cfg_we` = 1 and `cfg_target` = 0, `cfg_data` replaces the whole select mask. When `cfg_we` = 1 and `cfg_target` = 1, `cfg_data[7:0]` is loaded into the count of line `cfg_idx`. A load takes precedence over a decrement in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 16 | Request pulses, one per line |
| glb_en | input | 1 | Global dispatch enable |
| line_mask | input | 16 | Per-line dispatch enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_target | input | 1 | 0: select mask, 1: channel count |
| cfg_idx | input | 4 | Channel addressed by a count load |
| cfg_data | input | 16 | Write data |
| xfer_dec | input | 16 | Per-channel decrement strobes from the transfer engine |
| insn_end | input | 1 | Instruction boundary strobe |
| late_phase | input | 1 | Processor is in the last four state times of an instruction |
| disp_valid | output | 1 | A dispatch starts |
| disp_vec | output | 16 | Vector address of the dispatch |
| disp_xfer | output | 1 | 1: transfer service, 0: normal routine |

## Verification
The assertions check four things on every cycle:
- a dispatch only ever follows an enabled instruction boundary;
- each vector falls inside the table that matches `disp_xfer`;
- an end-of-service request never rises while its line is still routed to transfer service;
- an end-of-service bit only drops together with a normal-vector dispatch.

Three behaviours need the bench's scenarios: priority order among several lines, the one-boundary deferral of late-phase arrivals, and the full sequence from count exhaustion to a normal-vectored end-of-service dispatch. The behavioural model checks these cycle by cycle.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  typedef enum logic {
    CFG_SEL = 1'b0,
    CFG_CNT = 1'b1
  } cfg_tgt_e;
endpackage

// File: rtl/irqd_chan.sv
// Countdown counter for one transfer channel.
module irqd_chan #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero_hit
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             nonzero;

  always_comb begin
    nonzero  = (cnt_q != '0);
    cnt_en   = load | (dec & nonzero);
    cnt_d    = load ? load_val : (cnt_q - CNT_W'(1));
    zero_hit = dec & ~load & (cnt_q == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/irqd_arbiter.sv
// Fixed priority: the highest set index wins.
module irqd_arbiter #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     cand,
  output logic             hit,
  output logic [IDX_W-1:0] win
);
  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i]) begin
        hit = 1'b1;
        win = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_xfer_dispatch.sv
module irq_xfer_dispatch
  import irqd_pkg::*;
#(
  parameter int             N_LINES    = 16,
  parameter int             CNT_W      = 8,
  parameter int             VEC_W      = 16,
  parameter logic [VEC_W-1:0] NORM_BASE  = 16'h2020,
  parameter logic [VEC_W-1:0] XFER_BASE  = 16'h2040,
  parameter int             VEC_STRIDE = 2,
  localparam int            IDX_W      = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_req,
  input  logic               glb_en,
  input  logic [N_LINES-1:0] line_mask,
  input  logic               cfg_we,
  input  logic               cfg_target,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [N_LINES-1:0] cfg_data,
  input  logic [N_LINES-1:0] xfer_dec,
  input  logic               insn_end,
  input  logic               late_phase,
  output logic               disp_valid,
  output logic [VEC_W-1:0]   disp_vec,
  output logic               disp_xfer
);
  localparam logic [N_LINES-1:0] ONE_HOT0 = {{(N_LINES-1){1'b0}}, 1'b1};

  logic [N_LINES-1:0] sel_q, sel_d;
  logic [N_LINES-1:0] pend_q, pend_d;
  logic [N_LINES-1:0] young_q, young_d;
  logic [N_LINES-1:0] eos_q, eos_d;
  logic [N_LINES-1:0] zero_hit;
  logic [N_LINES-1:0] cnt_load;
  logic [N_LINES-1:0] cand;
  logic [N_LINES-1:0] win_oh, eos_clr, pend_clr;
  logic               sel_wr;
  logic               hit, take, win_eos, win_xfer;
  logic [IDX_W-1:0]   win;
  logic               valid_d, xfer_d;
  logic [VEC_W-1:0]   vec_d;

  // Per-line transfer channels
  generate
    for (genvar g = 0; g < N_LINES; g++) begin : g_chan
      assign cnt_load[g] = cfg_we && (cfg_target == CFG_CNT) && (cfg_idx == IDX_W'(g));
      irqd_chan #(.CNT_W(CNT_W)) i_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load[g]),
        .load_val (cfg_data[CNT_W-1:0]),
        .dec      (xfer_dec[g]),
        .zero_hit (zero_hit[g])
      );
    end
  endgenerate

  // Eligibility: end-of-service always, ordinary requests once mature
  always_comb begin
    cand = (eos_q | (pend_q & ~young_q)) & line_mask;
  end

  irqd_arbiter #(.N(N_LINES), .IDX_W(IDX_W)) i_arb (
    .cand (cand),
    .hit  (hit),
    .win  (win)
  );

  // Next state
  always_comb begin
    sel_wr   = cfg_we && (cfg_target == CFG_SEL);
    take     = insn_end & glb_en & hit;
    win_oh   = ONE_HOT0 << win;
    win_eos  = eos_q[win];
    win_xfer = ~win_eos & sel_q[win];
    eos_clr  = (take &  win_eos) ? win_oh : '0;
    pend_clr = (take & ~win_eos) ? win_oh : '0;

    sel_d   = (sel_wr ? cfg_data : sel_q) & ~zero_hit;
    eos_d   = (eos_q & ~eos_clr) | (zero_hit & sel_q);
    pend_d  = (pend_q & ~pend_clr) | irq_req;
    young_d = insn_end ? '0 : (young_q | (irq_req & {N_LINES{late_phase}}));

    valid_d = take;
    xfer_d  = win_xfer;
    vec_d   = (win_xfer ? XFER_BASE : NORM_BASE)
            + VEC_W'(win) * VEC_W'(VEC_STRIDE);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      eos_q   <= '0;
      pend_q  <= '0;
      young_q <= '0;
    end else begin
      sel_q   <= sel_d;
      eos_q   <= eos_d;
      pend_q  <= pend_d;
      young_q <= young_d;
    end
  end

  // Output registers; vector and flag load only on a dispatch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_valid <= 1'b0;
      disp_vec   <= '0;
      disp_xfer  <= 1'b0;
    end else begin
      disp_valid <= valid_d;
      if (take) begin
        disp_vec  <= vec_d;
        disp_xfer <= xfer_d;
      end
    end
  end
endmodule

// File: rtl/irq_xfer_dispatch_chk.sv
module irq_xfer_dispatch_chk #(
  parameter int               N_LINES    = 16,
  parameter int               VEC_W      = 16,
  parameter logic [VEC_W-1:0] NORM_BASE  = 16'h2020,
  parameter logic [VEC_W-1:0] XFER_BASE  = 16'h2040,
  parameter int               VEC_STRIDE = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               insn_end,
  input logic               glb_en,
  input logic               disp_valid,
  input logic [VEC_W-1:0]   disp_vec,
  input logic               disp_xfer,
  input logic [N_LINES-1:0] sel_q,
  input logic [N_LINES-1:0] eos_q
);
  localparam int NORM_LO = int'(NORM_BASE);
  localparam int NORM_HI = int'(NORM_BASE) + N_LINES * VEC_STRIDE;
  localparam int XFER_LO = int'(XFER_BASE);
  localparam int XFER_HI = int'(XFER_BASE) + N_LINES * VEC_STRIDE;

  assert_ack_at_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> ($past(insn_end) && $past(glb_en)));

  assert_normal_table_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_xfer) |->
      (int'(disp_vec) >= NORM_LO && int'(disp_vec) < NORM_HI));

  assert_xfer_table_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_xfer) |->
      (int'(disp_vec) >= XFER_LO && int'(disp_vec) < XFER_HI));

  generate
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
      assert_eos_unrouted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eos_q[g]) |-> !sel_q[g]);
      assert_eos_clear_normal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eos_q[g]) |-> (disp_valid && !disp_xfer));
    end
  endgenerate
endmodule

bind irq_xfer_dispatch irq_xfer_dispatch_chk #(
  .N_LINES    (N_LINES),
  .VEC_W      (VEC_W),
  .NORM_BASE  (NORM_BASE),
  .XFER_BASE  (XFER_BASE),
  .VEC_STRIDE (VEC_STRIDE)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .insn_end   (insn_end),
  .glb_en     (glb_en),
  .disp_valid (disp_valid),
  .disp_vec   (disp_vec),
  .disp_xfer  (disp_xfer),
  .sel_q      (sel_q),
  .eos_q      (eos_q)
);

// File: tb/test_irq_xfer_dispatch.sv
`timescale 1ns/1ps
module test_irq_xfer_dispatch;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_req;
  logic        glb_en;
  logic [15:0] line_mask;
  logic        cfg_we;
  logic        cfg_target;
  logic [3:0]  cfg_idx;
  logic [15:0] cfg_data;
  logic [15:0] xfer_dec;
  logic        insn_end;
  logic        late_phase;
  logic        disp_valid;
  logic [15:0] disp_vec;
  logic        disp_xfer;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_xfer_dispatch i_irq_xfer_dispatch (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .glb_en(glb_en),
    .line_mask(line_mask), .cfg_we(cfg_we), .cfg_target(cfg_target),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .xfer_dec(xfer_dec),
    .insn_end(insn_end), .late_phase(late_phase),
    .disp_valid(disp_valid), .disp_vec(disp_vec), .disp_xfer(disp_xfer)
  );

  // Behavioural reference model
  bit m_pend[16], m_young[16], m_eos[16], m_sel[16];
  int m_cnt[16];
  bit e_valid;
  int e_vec;
  bit e_xfer;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin
        m_pend[i] = 0; m_young[i] = 0; m_eos[i] = 0; m_sel[i] = 0; m_cnt[i] = 0;
      end
      e_valid = 0;
    end else begin
      int w;
      w = -1;
      for (int i = 0; i < 16; i++)
        if (line_mask[i] && (m_eos[i] || (m_pend[i] && !m_young[i]))) w = i;
      e_valid = 0;
      if (insn_end && glb_en && w >= 0) begin
        e_valid = 1;
        if (m_eos[w]) begin
          e_vec = 'h2020 + 2 * w; e_xfer = 0; m_eos[w] = 0;
        end else begin
          e_xfer = m_sel[w];
          e_vec  = (m_sel[w] ? 'h2040 : 'h2020) + 2 * w;
          m_pend[w] = 0;
        end
      end
      for (int i = 0; i < 16; i++) begin
        bit ld, zh, old_sel;
        ld = cfg_we && cfg_target && (int'(cfg_idx) == i);
        zh = xfer_dec[i] && !ld && (m_cnt[i] == 1);
        old_sel = m_sel[i];
        if (ld) m_cnt[i] = int'(cfg_data[7:0]);
        else if (xfer_dec[i] && m_cnt[i] != 0) m_cnt[i] = m_cnt[i] - 1;
        if (cfg_we && !cfg_target) m_sel[i] = cfg_data[i];
        if (zh) begin
          m_sel[i] = 0;
          if (old_sel) m_eos[i] = 1;
        end
        if (insn_end) m_young[i] = 0;
        else if (irq_req[i] && late_phase) m_young[i] = 1;
        if (irq_req[i]) m_pend[i] = 1;
      end
    end
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (disp_valid !== e_valid) begin
        errors++;
        $display("FAIL R2 model: disp_valid=%0b expected %0b at %0t", disp_valid, e_valid, $time);
      end else if (e_valid && (disp_vec !== 16'(e_vec) || disp_xfer !== e_xfer)) begin
        errors++;
        $display("FAIL R4/R5 model: vec=%h xfer=%0b expected vec=%h xfer=%0b at %0t",
                 disp_vec, disp_xfer, 16'(e_vec), e_xfer, $time);
      end
    end
  end

  task automatic chk(input bit v, input logic [15:0] vec, input bit x, input string tag);
    checks++;
    if (disp_valid !== v || (v && (disp_vec !== vec || disp_xfer !== x))) begin
      errors++;
      $display("FAIL %s: valid=%0b vec=%h xfer=%0b expected valid=%0b vec=%h xfer=%0b",
               tag, disp_valid, disp_vec, disp_xfer, v, vec, x);
    end
  endtask

  task automatic req(input logic [15:0] m, input bit late);
    irq_req = m; late_phase = late;
    @(negedge clk);
    irq_req = '0; late_phase = 0;
  endtask

  task automatic boundary();
    insn_end = 1;
    @(negedge clk);
    insn_end = 0;
  endtask

  task automatic wr_sel(input logic [15:0] m);
    cfg_we = 1; cfg_target = 0; cfg_data = m;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic ld_cnt(input int idx, input int val);
    cfg_we = 1; cfg_target = 1; cfg_idx = 4'(idx); cfg_data = 16'(val);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic dec(input logic [15:0] m);
    xfer_dec = m;
    @(negedge clk);
    xfer_dec = '0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    summary();
  end

  initial begin
    rst_n = 0; irq_req = '0; glb_en = 1; line_mask = 16'hFFFF; cfg_we = 0;
    cfg_target = 0; cfg_idx = '0; cfg_data = '0; xfer_dec = '0; insn_end = 0; late_phase = 0;
    repeat (3) @(negedge clk);
    chk(0, 0, 0, "R1 in reset");
    rst_n = 1;
    @(negedge clk);
    chk(0, 0, 0, "R1 after reset");

    // R2 / R4: wait for a boundary
    req(16'h0008, 0);
    repeat (3) @(negedge clk);
    chk(0, 0, 0, "R2 no boundary");
    boundary();
    chk(1, 16'h2026, 0, "R4 line3 normal");
    @(negedge clk);
    chk(0, 0, 0, "R2 single pulse");

    // R3 priority order, R9 clear on dispatch
    req(16'h0224, 0);
    boundary(); chk(1, 16'h2032, 0, "R3 line9 first");
    boundary(); chk(1, 16'h202A, 0, "R3 line5 second");
    boundary(); chk(1, 16'h2024, 0, "R3 line2 third");
    boundary(); chk(0, 0, 0, "R9 pending cleared");

    // R9 line mask holds a line pending
    line_mask = 16'hFF7F;
    req(16'h0080, 0);
    boundary(); chk(0, 0, 0, "R9 masked line");
    line_mask = 16'hFFFF;
    boundary(); chk(1, 16'h202E, 0, "R9 unmasked line7");
    // R2 global enable
    glb_en = 0;
    req(16'h0010, 0);
    boundary(); chk(0, 0, 0, "R2 global disable");
    glb_en = 1;
    boundary(); chk(1, 16'h2028, 0, "R2 global enable line4");

    // R10 / R5 transfer routing
    wr_sel(16'h0800);
    ld_cnt(11, 2);
    req(16'h0800, 0);
    boundary(); chk(1, 16'h2056, 1, "R5 line11 transfer");

    // R6 countdown, R7 end-of-service
    dec(16'h0800);
    req(16'h0800, 0);
    boundary(); chk(1, 16'h2056, 1, "R6 count one still transfer");
    dec(16'h0800);
    boundary(); chk(1, 16'h2036, 0, "R7 eos normal vector");
    boundary(); chk(0, 0, 0, "R7 eos cleared");
    req(16'h0800, 0);
    boundary(); chk(1, 16'h2036, 0, "R6 select cleared");
    wr_sel(16'h0800);
    dec(16'h0800);
    boundary(); chk(0, 0, 0, "R6 dec at zero no eos");
    req(16'h0800, 0);
    boundary(); chk(1, 16'h2056, 1, "R6 select kept at zero");

    // R10 load beats decrement
    wr_sel(16'h0040);
    cfg_we = 1; cfg_target = 1; cfg_idx = 4'd6; cfg_data = 16'd1; xfer_dec = 16'h0040;
    @(negedge clk);
    cfg_we = 0; xfer_dec = '0;
    boundary(); chk(0, 0, 0, "R10 load wins over dec");
    dec(16'h0040);
    req(16'h0420, 0);
    boundary(); chk(1, 16'h2034, 0, "R7 line10 above eos6");
    boundary(); chk(1, 16'h202C, 0, "R7 eos6 same priority");
    boundary(); chk(1, 16'h202A, 0, "R7 line5 after eos6");

    // R8 late-phase deferral
    req(16'h2000, 1);
    boundary(); chk(0, 0, 0, "R8 late arrival deferred");
    boundary(); chk(1, 16'h203A, 0, "R8 served next boundary");
    req(16'h2000, 0);
    boundary(); chk(1, 16'h203A, 0, "R8 early arrival served");

    repeat (4) @(negedge clk);
    summary();
  end
endmodule